// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block orders the memory requests waiting on one DRAM channel. Requests arrive on an enqueue port carrying a bank number, a row number, a write flag and a tag. Reads and writes go into two separate request buffers, each with its own capacity. The memory controller asks for work one bank at a time. With each request it gives the row that is currently open in that bank. One cycle later the scheduler answers with the request to issue, or with no grant.

Selection is first-ready, first-come-first-served. When the bank has no row lock, a queued request that targets the open row wins (a row hit). If none does, the oldest request in the bank wins (a row miss). In both cases the chosen row becomes locked. While the row stays locked, the scheduler keeps granting that row's requests, oldest first, until none remain, and each of these grants counts as a hit.

A two-state service-mode machine picks which buffer serves the grant. Its states are MODE_RD and MODE_WR. The transition RD_TO_WR fires when the number of pending writes reaches a high watermark, or when the requested bank holds writes but no reads. The transition WR_TO_RD fires when pending writes fall below a low watermark, or when the bank holds reads but no writes. Each buffer keeps its own per-bank lock state machine with the states LK_FREE and LK_HELD. The transition LOCK fires on a grant that leaves requests in the granted row, and RELEASE fires on the grant that drains that row. Six statistics counters record the grants.

Top module: `ddr_rowhit_sched`

## Requirements
- R1: An enqueue aimed at a buffer that holds its full capacity at the clock edge is dropped, and `enq_error` is high in the following cycle. This holds even when a grant frees a slot of that buffer in the same cycle. An enqueue to a buffer with room is stored, and `enq_error` stays low.
- R2: A grant shows on `gnt_valid` exactly one cycle after the `sch_valid` cycle that caused it. `gnt_row`, `gnt_tag` and `gnt_write` carry the request's row, its tag and its buffer (1 = write buffer).
- R3: When the bank's lock for the serving buffer is LK_FREE and requests in that bank target `sch_open_row`, the oldest of them is granted with `gnt_hit` = 1.
- R4: When the lock is LK_FREE and no request matches the open row, the oldest request in the bank is granted with `gnt_hit` = 0. Its row becomes locked if other requests to that row remain.
- R5: While a lock is LK_HELD, grants for that bank and buffer come only from the locked row, oldest first, whatever the open row is. Each of them has `gnt_hit` = 1. The grant that takes the last request of that row returns the lock to LK_FREE.
- R6: In MODE_RD, a schedule request moves the mode to MODE_WR when the write buffer holds at least WR_HI_MARK requests, or when the requested bank has writes but no reads. That grant is already served from the write buffer.
- R7: In MODE_WR, a schedule request moves the mode to MODE_RD when the write buffer holds fewer than WR_LO_MARK requests, or when the requested bank has reads but no writes. `wr_mode` shows the mode register (1 = MODE_WR) one cycle after the request.
- R8: The read and write buffers keep separate per-bank locks. A read-row lock survives any number of write-mode grants and resumes when read mode returns.
- R9: When the serving buffer has no request for the requested bank, no grant is produced and the counters and lock states are unchanged.
- R10: Every grant adds one to `stat_access` and one to `stat_reads` or `stat_writes`. A hit grant also adds one to `stat_hits` and to `stat_rd_hits` or `stat_wr_hits`. Counters change on no other cycle.
- R11: After reset the buffers are empty, every lock is LK_FREE, the mode is MODE_RD, the counters are zero, and `gnt_valid` and `enq_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue strobe |
| enq_bank | input | BANK_W | Bank of the new request |
| enq_row | input | ROW_W | Row of the new request |
| enq_write | input | 1 | 1 = write request, 0 = read request |
| enq_tag | input | TAG_W | Tag returned with the grant |
| enq_error | output | 1 | Previous enqueue hit a full buffer and was dropped |
| sch_valid | input | 1 | Schedule request for one bank |
| sch_bank | input | BANK_W | Bank being scheduled |
| sch_open_row | input | ROW_W | Row currently open in that bank |
| gnt_valid | output | 1 | A request was granted |
| gnt_write | output | 1 | Granted request came from the write buffer |
| gnt_hit | output | 1 | Grant counted as a row hit |
| gnt_row | output | ROW_W | Row of the granted request |
| gnt_tag | output | TAG_W | Tag of the granted request |
| wr_mode | output | 1 | Service mode register, 1 = MODE_WR |
| stat_access | output | CNT_W | Total grants |
| stat_reads | output | CNT_W | Read grants |
| stat_writes | output | CNT_W | Write grants |
| stat_hits | output | CNT_W | Hit grants |
| stat_rd_hits | output | CNT_W | Read hit grants |
| stat_wr_hits | output | CNT_W | Write hit grants |

## Verification
An enqueue and a grant can fall in the same cycle, and the case is sharpest when both touch one buffer. Occupancy and the pending-write count are then judged on their values before the edge: a full buffer still rejects, the new request cannot win that grant, and the mode decision ignores it. A directed case fills the read buffer and then enqueues and schedules the same bank in one cycle. The random phase raises both strobes together in about a quarter of its cycles. A bench model applies the grant first and the enqueue second, and each cycle it compares the grant fields, the error flag, the mode and all counters.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic {
        MODE_RD = 1'b0,
        MODE_WR = 1'b1
    } svc_mode_e;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;
endpackage

// File: rtl/sched_buffer.sv
// Request storage for one buffer. Each entry's age equals the number of
// valid entries newer than it, so ages are unique and bounded by DEPTH-1.
module sched_buffer #(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    parameter int TAG_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enq_en,
    input  logic [BANK_W-1:0]         enq_bank,
    input  logic [ROW_W-1:0]          enq_row,
    input  logic [TAG_W-1:0]          enq_tag,
    input  logic                      deq_en,
    input  logic [$clog2(DEPTH)-1:0]  deq_idx,
    output logic                      full,
    output logic [$clog2(DEPTH+1)-1:0] occ,
    output logic [DEPTH-1:0]          ent_v,
    output logic [BANK_W-1:0]         ent_bank [DEPTH],
    output logic [ROW_W-1:0]          ent_row  [DEPTH],
    output logic [TAG_W-1:0]          ent_tag  [DEPTH],
    output logic [$clog2(DEPTH)-1:0]  ent_age  [DEPTH]
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] AGE_ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] AGE_ZERO = '0;
    localparam logic [OCC_W-1:0] OCC_ONE  = OCC_W'(1);

    logic             enq_acc;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    always_comb begin
        occ = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_v[i]) occ = occ + OCC_ONE;
        end
        full = (occ == OCC_W'(DEPTH));
    end

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!ent_v[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign enq_acc = enq_en && free_found;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_bank[i] <= '0;
                ent_row[i]  <= '0;
                ent_tag[i]  <= '0;
                ent_age[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ent_v[i]) begin
                    ent_age[i] <= ent_age[i]
                                + (enq_acc ? AGE_ONE : AGE_ZERO)
                                - ((deq_en && ent_age[i] > ent_age[deq_idx]) ? AGE_ONE : AGE_ZERO);
                end
                if (deq_en && deq_idx == IDX_W'(i)) begin
                    ent_v[i] <= 1'b0;
                end
                if (enq_acc && free_idx == IDX_W'(i)) begin
                    ent_v[i]    <= 1'b1;
                    ent_bank[i] <= enq_bank;
                    ent_row[i]  <= enq_row;
                    ent_tag[i]  <= enq_tag;
                    ent_age[i]  <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/sched_pick.sv
// Finds the oldest entry of one bank, optionally restricted to one row,
// and counts how many entries match.
module sched_pick #(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8
) (
    input  logic [DEPTH-1:0]           ent_v,
    input  logic [BANK_W-1:0]          ent_bank [DEPTH],
    input  logic [ROW_W-1:0]           ent_row  [DEPTH],
    input  logic [$clog2(DEPTH)-1:0]   ent_age  [DEPTH],
    input  logic [BANK_W-1:0]          bank,
    input  logic                       row_en,
    input  logic [ROW_W-1:0]           row,
    output logic                       found,
    output logic [$clog2(DEPTH)-1:0]   idx,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [OCC_W-1:0] OCC_ONE = OCC_W'(1);

    logic [IDX_W-1:0] best_age;

    always_comb begin
        found    = 1'b0;
        idx      = '0;
        cnt      = '0;
        best_age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_v[i] && ent_bank[i] == bank && (!row_en || ent_row[i] == row)) begin
                cnt = cnt + OCC_ONE;
                if (!found || ent_age[i] > best_age) begin
                    found    = 1'b1;
                    idx      = IDX_W'(i);
                    best_age = ent_age[i];
                end
            end
        end
    end
endmodule

// File: rtl/sched_lane.sv
// One buffer plus its candidate selection for the requested bank.
module sched_lane #(
    parameter int DEPTH     = 8,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 8,
    parameter int TAG_W     = 6,
    parameter int OCC_OUT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enq_en,
    input  logic [BANK_W-1:0]    enq_bank,
    input  logic [ROW_W-1:0]     enq_row,
    input  logic [TAG_W-1:0]     enq_tag,
    input  logic [BANK_W-1:0]    sch_bank,
    input  logic [ROW_W-1:0]     open_row,
    input  logic                 lock_held,
    input  logic [ROW_W-1:0]     lock_row,
    input  logic                 take,
    output logic                 full,
    output logic [OCC_OUT_W-1:0] occ,
    output logic                 has_any,
    output logic                 cand_found,
    output logic                 cand_hit,
    output logic                 cand_last,
    output logic [ROW_W-1:0]     cand_row,
    output logic [TAG_W-1:0]     cand_tag
);
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int OCC_W   = $clog2(DEPTH + 1);
    localparam int NPICK   = 3;
    localparam int PK_LOCK = 0;
    localparam int PK_OPEN = 1;
    localparam int PK_ANY  = 2;
    localparam logic [OCC_W-1:0] OCC_ONE = OCC_W'(1);

    logic [DEPTH-1:0]  ent_v;
    logic [BANK_W-1:0] ent_bank [DEPTH];
    logic [ROW_W-1:0]  ent_row  [DEPTH];
    logic [TAG_W-1:0]  ent_tag  [DEPTH];
    logic [IDX_W-1:0]  ent_age  [DEPTH];
    logic [OCC_W-1:0]  buf_occ;

    logic             pk_found [NPICK];
    logic [IDX_W-1:0] pk_idx   [NPICK];
    logic [OCC_W-1:0] pk_cnt   [NPICK];

    logic [ROW_W-1:0] same_row;
    logic             same_found;
    logic [IDX_W-1:0] same_idx;
    logic [OCC_W-1:0] same_cnt;
    logic [IDX_W-1:0] sel_idx;
    logic             deq_en;

    sched_buffer #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .enq_en(enq_en), .enq_bank(enq_bank), .enq_row(enq_row), .enq_tag(enq_tag),
        .deq_en(deq_en), .deq_idx(sel_idx),
        .full(full), .occ(buf_occ),
        .ent_v(ent_v), .ent_bank(ent_bank), .ent_row(ent_row),
        .ent_tag(ent_tag), .ent_age(ent_age)
    );

    for (genvar k = 0; k < NPICK; k++) begin : g_pick
        sched_pick #(
            .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)
        ) u_pick (
            .ent_v(ent_v), .ent_bank(ent_bank), .ent_row(ent_row), .ent_age(ent_age),
            .bank(sch_bank),
            .row_en(k != PK_ANY),
            .row(k == PK_LOCK ? lock_row : open_row),
            .found(pk_found[k]), .idx(pk_idx[k]), .cnt(pk_cnt[k])
        );
    end

    // Row of the oldest request in the bank; its own group decides the miss grant.
    assign same_row = ent_row[pk_idx[PK_ANY]];

    sched_pick #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_pick_same (
        .ent_v(ent_v), .ent_bank(ent_bank), .ent_row(ent_row), .ent_age(ent_age),
        .bank(sch_bank), .row_en(1'b1), .row(same_row),
        .found(same_found), .idx(same_idx), .cnt(same_cnt)
    );

    always_comb begin
        if (lock_held) begin
            cand_found = pk_found[PK_LOCK];
            sel_idx    = pk_idx[PK_LOCK];
            cand_hit   = 1'b1;
            cand_last  = (pk_cnt[PK_LOCK] == OCC_ONE);
        end else if (pk_found[PK_OPEN]) begin
            cand_found = 1'b1;
            sel_idx    = pk_idx[PK_OPEN];
            cand_hit   = 1'b1;
            cand_last  = (pk_cnt[PK_OPEN] == OCC_ONE);
        end else begin
            cand_found = pk_found[PK_ANY] && same_found;
            sel_idx    = same_idx;
            cand_hit   = 1'b0;
            cand_last  = (same_cnt == OCC_ONE);
        end
    end

    assign cand_row = ent_row[sel_idx];
    assign cand_tag = ent_tag[sel_idx];
    assign has_any  = (pk_cnt[PK_ANY] != '0);
    assign deq_en   = take && cand_found;
    assign occ      = OCC_OUT_W'(buf_occ);
endmodule

// File: rtl/sched_mode_fsm.sv
// Read/write service mode with watermark and per-bank override transitions.
module sched_mode_fsm
    import sched_pkg::*;
#(
    parameter int PEND_W  = 4,
    parameter int HI_MARK = 6,
    parameter int LO_MARK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [PEND_W-1:0] wr_pend,
    input  logic              bank_has_rd,
    input  logic              bank_has_wr,
    output svc_mode_e         mode_eff,
    output logic              mode_is_wr
);
    svc_mode_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            MODE_RD: begin
                if (int'(wr_pend) >= HI_MARK || (!bank_has_rd && bank_has_wr))
                    state_n = MODE_WR;
            end
            MODE_WR: begin
                if (int'(wr_pend) < LO_MARK || (bank_has_rd && !bank_has_wr))
                    state_n = MODE_RD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_RD;
        else if (evt) state_q <= state_n;
    end

    always_comb begin
        mode_eff   = evt ? state_n : state_q;
        mode_is_wr = (state_q == MODE_WR);
    end
endmodule

// File: rtl/ddr_rowhit_sched.sv
module ddr_rowhit_sched
    import sched_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ROW_W      = 8,
    parameter int TAG_W      = 6,
    parameter int RD_DEPTH   = 8,
    parameter int WR_DEPTH   = 8,
    parameter int WR_HI_MARK = 6,
    parameter int WR_LO_MARK = 2,
    parameter int CNT_W      = 16,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic              enq_write,
    input  logic [TAG_W-1:0]  enq_tag,
    output logic              enq_error,
    input  logic              sch_valid,
    input  logic [BANK_W-1:0] sch_bank,
    input  logic [ROW_W-1:0]  sch_open_row,
    output logic              gnt_valid,
    output logic              gnt_write,
    output logic              gnt_hit,
    output logic [ROW_W-1:0]  gnt_row,
    output logic [TAG_W-1:0]  gnt_tag,
    output logic              wr_mode,
    output logic [CNT_W-1:0]  stat_access,
    output logic [CNT_W-1:0]  stat_reads,
    output logic [CNT_W-1:0]  stat_writes,
    output logic [CNT_W-1:0]  stat_hits,
    output logic [CNT_W-1:0]  stat_rd_hits,
    output logic [CNT_W-1:0]  stat_wr_hits
);
    localparam int MAX_DEPTH = (RD_DEPTH > WR_DEPTH) ? RD_DEPTH : WR_DEPTH;
    localparam int PEND_W    = $clog2(MAX_DEPTH + 1);
    localparam int NBUF      = 2;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    lock_state_e     lk_st  [NBUF][NUM_BANKS];
    logic [ROW_W-1:0] lk_row [NBUF][NUM_BANKS];

    logic              ln_full  [NBUF];
    logic [PEND_W-1:0] ln_occ   [NBUF];
    logic              ln_any   [NBUF];
    logic              ln_found [NBUF];
    logic              ln_hit   [NBUF];
    logic              ln_last  [NBUF];
    logic [ROW_W-1:0]  ln_row   [NBUF];
    logic [TAG_W-1:0]  ln_tag   [NBUF];

    svc_mode_e mode_eff;
    logic      act_wr;
    logic      granted;

    sched_mode_fsm #(
        .PEND_W(PEND_W), .HI_MARK(WR_HI_MARK), .LO_MARK(WR_LO_MARK)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .evt(sch_valid),
        .wr_pend(ln_occ[1]), .bank_has_rd(ln_any[0]), .bank_has_wr(ln_any[1]),
        .mode_eff(mode_eff), .mode_is_wr(wr_mode)
    );

    assign act_wr  = (mode_eff == MODE_WR);
    assign granted = sch_valid && ln_found[act_wr];

    for (genvar gb = 0; gb < NBUF; gb++) begin : g_lane
        localparam int LANE_DEPTH = (gb == 0) ? RD_DEPTH : WR_DEPTH;
        sched_lane #(
            .DEPTH(LANE_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W),
            .TAG_W(TAG_W), .OCC_OUT_W(PEND_W)
        ) u_lane (
            .clk(clk), .rst_n(rst_n),
            .enq_en(enq_valid && (enq_write == 1'(gb))),
            .enq_bank(enq_bank), .enq_row(enq_row), .enq_tag(enq_tag),
            .sch_bank(sch_bank), .open_row(sch_open_row),
            .lock_held(lk_st[gb][sch_bank] == LK_HELD),
            .lock_row(lk_row[gb][sch_bank]),
            .take(sch_valid && (act_wr == 1'(gb))),
            .full(ln_full[gb]), .occ(ln_occ[gb]), .has_any(ln_any[gb]),
            .cand_found(ln_found[gb]), .cand_hit(ln_hit[gb]), .cand_last(ln_last[gb]),
            .cand_row(ln_row[gb]), .cand_tag(ln_tag[gb])
        );
    end

    // Per-bank lock machines: LOCK on a grant leaving requests, RELEASE on the draining grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBUF; b++) begin
                for (int k = 0; k < NUM_BANKS; k++) begin
                    lk_st[b][k]  <= LK_FREE;
                    lk_row[b][k] <= '0;
                end
            end
        end else if (granted) begin
            unique case (ln_last[act_wr])
                1'b1: lk_st[act_wr][sch_bank] <= LK_FREE;
                1'b0: lk_st[act_wr][sch_bank] <= LK_HELD;
            endcase
            lk_row[act_wr][sch_bank] <= ln_row[act_wr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            gnt_write <= 1'b0;
            gnt_hit   <= 1'b0;
            gnt_row   <= '0;
            gnt_tag   <= '0;
            enq_error <= 1'b0;
        end else begin
            gnt_valid <= granted;
            enq_error <= enq_valid && ln_full[enq_write];
            if (granted) begin
                gnt_write <= act_wr;
                gnt_hit   <= ln_hit[act_wr];
                gnt_row   <= ln_row[act_wr];
                gnt_tag   <= ln_tag[act_wr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_access  <= '0;
            stat_reads   <= '0;
            stat_writes  <= '0;
            stat_hits    <= '0;
            stat_rd_hits <= '0;
            stat_wr_hits <= '0;
        end else if (granted) begin
            stat_access <= stat_access + CNT_ONE;
            if (act_wr) stat_writes <= stat_writes + CNT_ONE;
            else        stat_reads  <= stat_reads + CNT_ONE;
            if (ln_hit[act_wr]) begin
                stat_hits <= stat_hits + CNT_ONE;
                if (act_wr) stat_wr_hits <= stat_wr_hits + CNT_ONE;
                else        stat_rd_hits <= stat_rd_hits + CNT_ONE;
            end
        end
    end
endmodule

// File: rtl/ddr_rowhit_sched_checks.sv
module ddr_rowhit_sched_checks #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic             enq_error,
    input logic             sch_valid,
    input logic             gnt_valid,
    input logic             gnt_hit,
    input logic             wr_mode,
    input logic [CNT_W-1:0] stat_access,
    input logic [CNT_W-1:0] stat_reads,
    input logic [CNT_W-1:0] stat_writes,
    input logic [CNT_W-1:0] stat_hits
);
    a_r1_err_needs_enq: assert property (@(posedge clk) disable iff (!rst_n)
        enq_error |-> $past(enq_valid));

    a_r2_gnt_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> $past(sch_valid));

    a_r6_to_wr_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_mode) |-> $past(sch_valid));

    a_r7_to_rd_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_mode) |-> $past(sch_valid));

    a_r10_idle_counters: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> ($stable(stat_access) && $stable(stat_hits)));

    a_r10_hit_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && gnt_hit) |-> (stat_hits != $past(stat_hits)));

    a_r10_split_sum: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(stat_reads + stat_writes) == stat_access);
endmodule

bind ddr_rowhit_sched ddr_rowhit_sched_checks #(.CNT_W(CNT_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_error(enq_error),
    .sch_valid(sch_valid), .gnt_valid(gnt_valid), .gnt_hit(gnt_hit),
    .wr_mode(wr_mode), .stat_access(stat_access), .stat_reads(stat_reads),
    .stat_writes(stat_writes), .stat_hits(stat_hits)
);

// File: tb/ddr_rowhit_sched_tb.sv
module ddr_rowhit_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 4;
    localparam int BW  = 2;
    localparam int RW  = 8;
    localparam int TW  = 6;
    localparam int RDD = 8;
    localparam int WRD = 8;
    localparam int HI  = 6;
    localparam int LO  = 2;
    localparam int CW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0, enq_write = 1'b0, sch_valid = 1'b0;
    logic [BW-1:0] enq_bank = '0, sch_bank = '0;
    logic [RW-1:0] enq_row = '0, sch_open_row = '0;
    logic [TW-1:0] enq_tag = '0;
    logic enq_error, gnt_valid, gnt_write, gnt_hit, wr_mode;
    logic [RW-1:0] gnt_row;
    logic [TW-1:0] gnt_tag;
    logic [CW-1:0] stat_access, stat_reads, stat_writes, stat_hits, stat_rd_hits, stat_wr_hits;

    ddr_rowhit_sched #(
        .NUM_BANKS(NB), .ROW_W(RW), .TAG_W(TW), .RD_DEPTH(RDD), .WR_DEPTH(WRD),
        .WR_HI_MARK(HI), .WR_LO_MARK(LO), .CNT_W(CW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_bank(enq_bank),
        .enq_row(enq_row), .enq_write(enq_write), .enq_tag(enq_tag), .enq_error(enq_error),
        .sch_valid(sch_valid), .sch_bank(sch_bank), .sch_open_row(sch_open_row),
        .gnt_valid(gnt_valid), .gnt_write(gnt_write), .gnt_hit(gnt_hit),
        .gnt_row(gnt_row), .gnt_tag(gnt_tag), .wr_mode(wr_mode),
        .stat_access(stat_access), .stat_reads(stat_reads), .stat_writes(stat_writes),
        .stat_hits(stat_hits), .stat_rd_hits(stat_rd_hits), .stat_wr_hits(stat_wr_hits)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference model state
    bit mv [2][8];
    int mbank [2][8];
    int mrow [2][8];
    int mtag [2][8];
    int mseq [2][8];
    bit mlk [2][NB];
    int mlkrow [2][NB];
    bit mmode = 1'b0;
    int gseq = 0;
    int c_acc = 0, c_rd = 0, c_wr = 0, c_hit = 0, c_rdh = 0, c_wrh = 0;
    bit e_gv, e_gw, e_gh, e_err;
    int e_grow, e_gtag;
    string e_lab;

    function automatic int depth_of(int b);
        return (b == 1) ? WRD : RDD;
    endfunction

    function automatic int occ_of(int b);
        int n = 0;
        for (int i = 0; i < depth_of(b); i++) if (mv[b][i]) n++;
        return n;
    endfunction

    function automatic int oldest(int b, int bank, bit use_row, int row);
        int s = -1;
        for (int i = 0; i < depth_of(b); i++) begin
            if (mv[b][i] && mbank[b][i] == bank && (!use_row || mrow[b][i] == row)) begin
                if (s < 0 || mseq[b][i] < mseq[b][s]) s = i;
            end
        end
        return s;
    endfunction

    function automatic int row_count(int b, int bank, int row);
        int n = 0;
        for (int i = 0; i < depth_of(b); i++)
            if (mv[b][i] && mbank[b][i] == bank && mrow[b][i] == row) n++;
        return n;
    endfunction

    task automatic model_step(input bit en, input int bank, input int row, input bit wr,
                              input int tag, input bit sv, input int sbank, input int orow);
        int slot, b;
        bit hr, hw;
        e_err = en && (occ_of(int'(wr)) == depth_of(int'(wr)));
        e_gv  = 1'b0;
        e_lab = "R9";
        if (sv) begin
            hr = oldest(0, sbank, 1'b0, 0) >= 0;
            hw = oldest(1, sbank, 1'b0, 0) >= 0;
            if (!mmode && (occ_of(1) >= HI || (!hr && hw))) mmode = 1'b1;
            else if (mmode && (occ_of(1) < LO || (hr && !hw))) mmode = 1'b0;
            b = int'(mmode);
            if (mlk[b][sbank]) begin
                slot = oldest(b, sbank, 1'b1, mlkrow[b][sbank]);
                e_gh = 1'b1; e_lab = "R5";
            end else begin
                slot = oldest(b, sbank, 1'b1, orow);
                e_gh = 1'b1; e_lab = "R3";
                if (slot < 0) begin
                    slot = oldest(b, sbank, 1'b0, 0);
                    e_gh = 1'b0; e_lab = "R4";
                end
            end
            if (slot >= 0) begin
                e_gv = 1'b1; e_gw = mmode;
                e_grow = mrow[b][slot]; e_gtag = mtag[b][slot];
                mv[b][slot] = 1'b0;
                if (row_count(b, sbank, e_grow) == 0) mlk[b][sbank] = 1'b0;
                else begin mlk[b][sbank] = 1'b1; mlkrow[b][sbank] = e_grow; end
                c_acc++;
                if (mmode) c_wr++; else c_rd++;
                if (e_gh) begin
                    c_hit++;
                    if (mmode) c_wrh++; else c_rdh++;
                end
            end else begin
                e_lab = "R9";
            end
        end
        if (en && !e_err) begin
            b = int'(wr);
            slot = -1;
            for (int i = 0; i < depth_of(b); i++) if (!mv[b][i] && slot < 0) slot = i;
            mv[b][slot] = 1'b1; mbank[b][slot] = bank; mrow[b][slot] = row;
            mtag[b][slot] = tag; mseq[b][slot] = gseq; gseq++;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit en, input int bank, input int row, input bit wr, input int tag,
                        input bit sv, input int sbank, input int orow, input string lab);
        string gl;
        enq_valid = en; enq_bank = BW'(bank); enq_row = RW'(row);
        enq_write = wr; enq_tag = TW'(tag);
        sch_valid = sv; sch_bank = BW'(sbank); sch_open_row = RW'(orow);
        model_step(en, bank, row, wr, tag, sv, sbank, orow);
        gl = (lab != "") ? lab : e_lab;
        @(posedge clk);
        @(negedge clk);
        check(gnt_valid == e_gv, gl, "gnt_valid", int'(gnt_valid), int'(e_gv));
        if (e_gv && gnt_valid) begin
            check(int'(gnt_row) == e_grow, "R2", "gnt_row", int'(gnt_row), e_grow);
            check(int'(gnt_tag) == e_gtag, "R2", "gnt_tag", int'(gnt_tag), e_gtag);
            check(gnt_write == e_gw, "R2", "gnt_write", int'(gnt_write), int'(e_gw));
            check(gnt_hit == e_gh, gl, "gnt_hit", int'(gnt_hit), int'(e_gh));
        end
        check(enq_error == e_err, "R1", "enq_error", int'(enq_error), int'(e_err));
        check(wr_mode == mmode, mmode ? "R6" : "R7", "wr_mode", int'(wr_mode), int'(mmode));
        check(int'(stat_access) == c_acc, "R10", "stat_access", int'(stat_access), c_acc);
        check(int'(stat_reads) == c_rd, "R10", "stat_reads", int'(stat_reads), c_rd);
        check(int'(stat_writes) == c_wr, "R10", "stat_writes", int'(stat_writes), c_wr);
        check(int'(stat_hits) == c_hit, "R10", "stat_hits", int'(stat_hits), c_hit);
        check(int'(stat_rd_hits) == c_rdh, "R10", "stat_rd_hits", int'(stat_rd_hits), c_rdh);
        check(int'(stat_wr_hits) == c_wrh, "R10", "stat_wr_hits", int'(stat_wr_hits), c_wrh);
    endtask

    task automatic enq(input int bank, input int row, input bit wr, input int tag);
        step(1'b1, bank, row, wr, tag, 1'b0, 0, 0, "");
    endtask

    task automatic sch(input int sbank, input int orow, input string lab);
        step(1'b0, 0, 0, 1'b0, 0, 1'b1, sbank, orow, lab);
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd20240);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(gnt_valid == 1'b0, "R11", "gnt_valid", int'(gnt_valid), 0);
        check(enq_error == 1'b0, "R11", "enq_error", int'(enq_error), 0);
        check(wr_mode == 1'b0, "R11", "wr_mode", int'(wr_mode), 0);
        check(stat_access == '0, "R11", "stat_access", int'(stat_access), 0);

        // Row selection: miss, locked drain, open-row hit, miss
        enq(0, 5, 1'b0, 1); enq(0, 3, 1'b0, 2); enq(0, 5, 1'b0, 3); enq(0, 7, 1'b0, 4);
        sch(0, 9, "R4");
        sch(0, 3, "R5");
        sch(0, 3, "R3");
        sch(0, 3, "R4");
        sch(0, 3, "R9");

        // Separate locks across a write burst
        enq(1, 10, 1'b0, 10); enq(1, 10, 1'b0, 11); enq(1, 20, 1'b0, 12);
        sch(1, 99, "R4");
        for (int i = 0; i < 6; i++) enq(1, 30, 1'b1, 20 + i);
        sch(1, 99, "R6");
        for (int i = 0; i < 4; i++) sch(1, 99, "R6");
        sch(1, 20, "R8");
        sch(1, 20, "R3");
        sch(1, 20, "R6");
        sch(1, 20, "R7");

        // Full buffer, including enqueue and grant in the same cycle
        for (int i = 0; i < RDD; i++) enq(2, i, 1'b0, 40 + i);
        enq(2, 9, 1'b0, 50);
        step(1'b1, 2, 9, 1'b0, 51, 1'b1, 2, 0, "R1");
        enq(2, 9, 1'b0, 52);
        for (int i = 0; i < RDD; i++) sch(2, 9, "");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 1) == 1, int'($urandom_range(0, NB - 1)),
                 int'($urandom_range(0, 3)), $urandom_range(0, 9) < 4,
                 int'($urandom_range(0, 63)),
                 $urandom_range(0, 1) == 1, int'($urandom_range(0, NB - 1)),
                 int'($urandom_range(0, 3)), "");
        end
        enq_valid = 1'b0;
        sch_valid = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule